// File: doc/BRIEF.md
# Aliased-Width General-Purpose Register File

This block holds sixteen 64-bit general-purpose registers. Software-visible operands can name a whole register or a narrower view of it: the low 32, low 16 or low 8 bits. On the first four registers there is also a second byte view covering bits 15:8. One write port accepts an index, a two-bit width code, a high-byte select, an extended-byte-form flag and data. It folds the data into the stored value using width-dependent rules. A 32-bit write clears the upper half. A 16-bit or 8-bit write leaves every bit outside its view untouched.

Two independent read ports each take an index, a width code and a high-byte select. Each returns the chosen view zero-extended to 64 bits. A high-byte view is shifted down into bits 7:0. Reads are combinational from the stored state and have no write bypass. A write lands on the rising clock edge, and a read in the same cycle still sees the old contents.

A high-byte write that the register cannot honour raises an illegal-access flag in the same cycle and is dropped. This covers a register without a high-byte view, and the extended byte form used together with a high-byte request.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) clears all sixteen registers to zero.
- R2: A write with width code 2'b11 replaces all 64 bits of the indexed register.
- R3: A write with width code 2'b10 stores data bits 31:0 into bits 31:0 and sets bits 63:32 of the register to zero.
- R4: A write with width code 2'b01 replaces bits 15:0 only; bits 63:16 keep their old value.
- R5: A write with width code 2'b00 and high select 0 replaces bits 7:0 only, on any of the sixteen indices.
- R6: A write with width code 2'b00, high select 1 and extended flag 0 to index 0 to 3 places data bits 7:0 into register bits 15:8 and keeps all other bits.
- R7: A write with width code 2'b00 and high select 1 is illegal when the index is 4 to 15 or the extended flag is 1. illegal_o is then high in that same cycle and no register changes. illegal_o is low for every other input.
- R8: The high select and the extended flag have no effect when the width code is not 2'b00.
- R9: A read returns the selected view zero-extended to 64 bits, using the same width codes. A byte read with high select 1 returns bits 15:8 in bits 7:0 for index 0 to 3, and returns zero for index 4 to 15.
- R10: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle.
- R11: With wr_en_i low, no register changes and illegal_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 4 | Destination register index |
| wr_size_i | input | 2 | Write width code (00 byte, 01 16-bit, 10 32-bit, 11 64-bit) |
| wr_hi_i | input | 1 | Select byte at bits 15:8 for byte writes |
| wr_xbyte_i | input | 1 | Extended byte form in use; forbids a high-byte write |
| wr_data_i | input | 64 | Write data, right aligned |
| illegal_o | output | 1 | Current write request is an illegal high-byte access |
| rd0_idx_i | input | 4 | Read port 0 register index |
| rd0_size_i | input | 2 | Read port 0 width code |
| rd0_hi_i | input | 1 | Read port 0 high-byte select |
| rd0_data_o | output | 64 | Read port 0 zero-extended view |
| rd1_idx_i | input | 4 | Read port 1 register index |
| rd1_size_i | input | 2 | Read port 1 width code |
| rd1_hi_i | input | 1 | Read port 1 high-byte select |
| rd1_data_o | output | 64 | Read port 1 zero-extended view |

## Verification
The bench builds the block with its defaults: sixteen registers of 64 bits, four of them with a high-byte view. Two consequences follow. The boundary between index 3 and index 4 is where legal high-byte access ends, and the bench writes on both sides of it. Every index, including the last one, is also reachable for both write merges and reads. Keeping a 64-bit width means each of the four views sits at a distinct bit boundary. A merge that spills into, or fails to clear, a neighbouring field therefore shows up as a wrong upper bit against the bench's own model.

// File: rtl/arf_pkg.sv
`timescale 1ns/1ps
package arf_pkg;

    // Width code shared by the write port and both read ports.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_FULL = 2'b11
    } size_e;

endpackage

// File: rtl/arf_access_check.sv
`timescale 1ns/1ps
// Decides whether a write request may proceed.
module arf_access_check #(
    parameter int NUM_REGS   = 16,
    parameter int NUM_HIBYTE = 4,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic              en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  arf_pkg::size_e    size_i,
    input  logic              hi_i,
    input  logic              xbyte_i,
    output logic              illegal_o,
    output logic              commit_o
);
    logic hi_req;
    logic no_hi_view;

    always_comb begin
        hi_req     = en_i && (size_i == arf_pkg::SZ_BYTE) && hi_i;
        no_hi_view = (int'(idx_i) >= NUM_HIBYTE);
        illegal_o  = hi_req && (no_hi_view || xbyte_i);
        commit_o   = en_i && !illegal_o;
    end
endmodule

// File: rtl/arf_wr_merge.sv
`timescale 1ns/1ps
// Folds new data into the old register value per width code.
module arf_wr_merge #(
    parameter int XLEN = 64,
    localparam int W32 = XLEN / 2,
    localparam int W16 = XLEN / 4,
    localparam int W8  = XLEN / 8
) (
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] data_i,
    input  arf_pkg::size_e  size_i,
    input  logic            hi_i,
    output logic [XLEN-1:0] merged_o
);
    always_comb begin
        unique case (size_i)
            arf_pkg::SZ_FULL: merged_o = data_i;
            arf_pkg::SZ_WORD: merged_o = {{(XLEN-W32){1'b0}}, data_i[W32-1:0]};
            arf_pkg::SZ_HALF: merged_o = {old_i[XLEN-1:W16], data_i[W16-1:0]};
            default: begin
                if (hi_i) begin
                    merged_o = {old_i[XLEN-1:2*W8], data_i[W8-1:0], old_i[W8-1:0]};
                end else begin
                    merged_o = {old_i[XLEN-1:W8], data_i[W8-1:0]};
                end
            end
        endcase
    end
endmodule

// File: rtl/arf_rd_view.sv
`timescale 1ns/1ps
// Extracts one zero-extended view of a register.
module arf_rd_view #(
    parameter int NUM_REGS   = 16,
    parameter int XLEN       = 64,
    parameter int NUM_HIBYTE = 4,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int W32       = XLEN / 2,
    localparam int W16       = XLEN / 4,
    localparam int W8        = XLEN / 8
) (
    input  logic [NUM_REGS-1:0][XLEN-1:0] regs_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  arf_pkg::size_e                size_i,
    input  logic                          hi_i,
    output logic [XLEN-1:0]               data_o
);
    logic [XLEN-1:0] sel;
    logic            has_hi;

    always_comb begin
        sel    = regs_i[idx_i];
        has_hi = (int'(idx_i) < NUM_HIBYTE);
        unique case (size_i)
            arf_pkg::SZ_FULL: data_o = sel;
            arf_pkg::SZ_WORD: data_o = {{(XLEN-W32){1'b0}}, sel[W32-1:0]};
            arf_pkg::SZ_HALF: data_o = {{(XLEN-W16){1'b0}}, sel[W16-1:0]};
            default: begin
                if (!hi_i) begin
                    data_o = {{(XLEN-W8){1'b0}}, sel[W8-1:0]};
                end else if (has_hi) begin
                    data_o = {{(XLEN-W8){1'b0}}, sel[2*W8-1:W8]};
                end else begin
                    data_o = '0;
                end
            end
        endcase
    end
endmodule

// File: rtl/alias_regfile.sv
`timescale 1ns/1ps
module alias_regfile #(
    parameter int NUM_REGS   = 16,
    parameter int XLEN       = 64,
    parameter int NUM_HIBYTE = 4,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int NUM_RD    = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [1:0]       wr_size_i,
    input  logic             wr_hi_i,
    input  logic             wr_xbyte_i,
    input  logic [XLEN-1:0]  wr_data_i,
    output logic             illegal_o,
    input  logic [IDX_W-1:0] rd0_idx_i,
    input  logic [1:0]       rd0_size_i,
    input  logic             rd0_hi_i,
    output logic [XLEN-1:0]  rd0_data_o,
    input  logic [IDX_W-1:0] rd1_idx_i,
    input  logic [1:0]       rd1_size_i,
    input  logic             rd1_hi_i,
    output logic [XLEN-1:0]  rd1_data_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0] gpr;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_REGS-1:0][XLEN-1:0] regs_q;
    logic                          commit;
    logic [XLEN-1:0]               merged;
    logic [XLEN-1:0]               wr_old;
    arf_pkg::size_e                wr_size;

    assign regs_q  = state_q.gpr;
    assign wr_size = arf_pkg::size_e'(wr_size_i);
    assign wr_old  = regs_q[wr_idx_i];

    arf_access_check #(
        .NUM_REGS   (NUM_REGS),
        .NUM_HIBYTE (NUM_HIBYTE)
    ) u_check (
        .en_i      (wr_en_i),
        .idx_i     (wr_idx_i),
        .size_i    (wr_size),
        .hi_i      (wr_hi_i),
        .xbyte_i   (wr_xbyte_i),
        .illegal_o (illegal_o),
        .commit_o  (commit)
    );

    arf_wr_merge #(
        .XLEN (XLEN)
    ) u_merge (
        .old_i    (wr_old),
        .data_i   (wr_data_i),
        .size_i   (wr_size),
        .hi_i     (wr_hi_i),
        .merged_o (merged)
    );

    // Read ports gathered into arrays so one generate loop serves both.
    logic [NUM_RD-1:0][IDX_W-1:0] rd_idx;
    logic [NUM_RD-1:0][1:0]       rd_size;
    logic [NUM_RD-1:0]            rd_hi;
    logic [NUM_RD-1:0][XLEN-1:0]  rd_data;

    assign rd_idx  = {rd1_idx_i,  rd0_idx_i};
    assign rd_size = {rd1_size_i, rd0_size_i};
    assign rd_hi   = {rd1_hi_i,   rd0_hi_i};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        arf_rd_view #(
            .NUM_REGS   (NUM_REGS),
            .XLEN       (XLEN),
            .NUM_HIBYTE (NUM_HIBYTE)
        ) u_view (
            .regs_i (regs_q),
            .idx_i  (rd_idx[p]),
            .size_i (arf_pkg::size_e'(rd_size[p])),
            .hi_i   (rd_hi[p]),
            .data_o (rd_data[p])
        );
    end

    assign rd0_data_o = rd_data[0];
    assign rd1_data_o = rd_data[1];

    always_comb begin
        state_d = state_q;
        if (rst_i) begin
            state_d.gpr = '0;
        end else if (commit) begin
            state_d.gpr[wr_idx_i] = merged;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end
endmodule

// File: rtl/arf_checker.sv
`timescale 1ns/1ps
module arf_checker #(
    parameter int NUM_REGS   = 16,
    parameter int XLEN       = 64,
    parameter int NUM_HIBYTE = 4,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int W32       = XLEN / 2,
    localparam int W16       = XLEN / 4,
    localparam int W8        = XLEN / 8
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic                          wr_en_i,
    input logic [IDX_W-1:0]              wr_idx_i,
    input logic [1:0]                    wr_size_i,
    input logic                          wr_hi_i,
    input logic [XLEN-1:0]               wr_data_i,
    input logic                          illegal_o,
    input logic [NUM_REGS-1:0][XLEN-1:0] regs_q,
    input logic [IDX_W-1:0]              rd0_idx_i,
    input logic [1:0]                    rd0_size_i,
    input logic                          rd0_hi_i,
    input logic [XLEN-1:0]               rd0_data_o
);
    p_full_write_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_size_i == 2'b11) |=> regs_q[$past(wr_idx_i)] == $past(wr_data_i));

    p_word_clear_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_size_i == 2'b10) |=> regs_q[$past(wr_idx_i)][XLEN-1:W32] == '0);

    p_half_keep_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_size_i == 2'b01)
        |=> regs_q[$past(wr_idx_i)][XLEN-1:W16] == $past(regs_q[wr_idx_i][XLEN-1:W16]));

    p_illegal_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |=> $stable(regs_q));

    p_illegal_cause_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> (wr_en_i && wr_size_i == 2'b00 && wr_hi_i));

    p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_en_i |=> $stable(regs_q));

    p_byte_view_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd0_size_i == 2'b00) |-> rd0_data_o[XLEN-1:W8] == '0);

    p_hi_absent_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd0_size_i == 2'b00 && rd0_hi_i && int'(rd0_idx_i) >= NUM_HIBYTE) |-> rd0_data_o == '0);
endmodule

bind alias_regfile arf_checker #(
    .NUM_REGS   (NUM_REGS),
    .XLEN       (XLEN),
    .NUM_HIBYTE (NUM_HIBYTE)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_size_i  (wr_size_i),
    .wr_hi_i    (wr_hi_i),
    .wr_data_i  (wr_data_i),
    .illegal_o  (illegal_o),
    .regs_q     (regs_q),
    .rd0_idx_i  (rd0_idx_i),
    .rd0_size_i (rd0_size_i),
    .rd0_hi_i   (rd0_hi_i),
    .rd0_data_o (rd0_data_o)
);

// File: tb/alias_regfile_tb.sv
`timescale 1ns/1ps
module alias_regfile_tb;
    localparam int CLK_NS = 8;

    typedef struct packed {
        logic [3:0]  idx;
        logic [1:0]  sz;
        logic        hi;
        logic        xb;
        logic [63:0] d;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  2'd3, 1'b0, 1'b0, 64'h1122_3344_5566_7788},
        '{4'd0,  2'd2, 1'b0, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD},
        '{4'd0,  2'd3, 1'b0, 1'b0, 64'hFFFF_EEEE_DDDD_CCCC},
        '{4'd0,  2'd1, 1'b0, 1'b0, 64'h9999_8888_7777_1234},
        '{4'd0,  2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_4456},
        '{4'd0,  2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_339A},
        '{4'd3,  2'd3, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF},
        '{4'd3,  2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF5A},
        '{4'd3,  2'd0, 1'b1, 1'b1, 64'h0000_0000_0000_00C3},
        '{4'd5,  2'd3, 1'b0, 1'b0, 64'hDEAD_BEEF_CAFE_F00D},
        '{4'd5,  2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_0077},
        '{4'd5,  2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0042},
        '{4'd15, 2'd3, 1'b0, 1'b0, 64'h8000_0000_0000_0001},
        '{4'd15, 2'd1, 1'b1, 1'b0, 64'h0000_0000_0000_ABCD},
        '{4'd15, 2'd2, 1'b1, 1'b1, 64'h5555_5555_7654_3210},
        '{4'd7,  2'd0, 1'b0, 1'b1, 64'h0000_0000_0000_00E1},
        '{4'd1,  2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_00B2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_hi, wr_xb;
    logic [3:0]  wr_idx;
    logic [1:0]  wr_size;
    logic [63:0] wr_data;
    logic        illegal;
    logic [3:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_size, rd1_size;
    logic        rd0_hi, rd1_hi;
    logic [63:0] rd0_data, rd1_data;

    int n_run  = 0;
    int n_fail = 0;
    logic [63:0] mdl [16];

    always #(CLK_NS/2) clk = ~clk;

    alias_regfile u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_size_i  (wr_size),
        .wr_hi_i    (wr_hi),
        .wr_xbyte_i (wr_xb),
        .wr_data_i  (wr_data),
        .illegal_o  (illegal),
        .rd0_idx_i  (rd0_idx),
        .rd0_size_i (rd0_size),
        .rd0_hi_i   (rd0_hi),
        .rd0_data_o (rd0_data),
        .rd1_idx_i  (rd1_idx),
        .rd1_size_i (rd1_size),
        .rd1_hi_i   (rd1_hi),
        .rd1_data_o (rd1_data)
    );

    function automatic logic is_illegal(logic [3:0] idx, logic [1:0] sz, logic hi, logic xb);
        return (sz == 2'b00) && hi && ((idx >= 4'd4) || xb);
    endfunction

    function automatic logic [63:0] mdl_view(logic [3:0] idx, logic [1:0] sz, logic hi);
        logic [63:0] r = mdl[idx];
        case (sz)
            2'b11: return r;
            2'b10: return {32'h0, r[31:0]};
            2'b01: return {48'h0, r[15:0]};
            default: begin
                if (!hi) return {56'h0, r[7:0]};
                if (idx < 4'd4) return {56'h0, r[15:8]};
                return 64'h0;
            end
        endcase
    endfunction

    function automatic void mdl_write(logic [3:0] idx, logic [1:0] sz, logic hi, logic [63:0] d);
        case (sz)
            2'b11: mdl[idx] = d;
            2'b10: mdl[idx] = {32'h0, d[31:0]};
            2'b01: mdl[idx][15:0] = d[15:0];
            default: begin
                if (hi) mdl[idx][15:8] = d[7:0];
                else    mdl[idx][7:0]  = d[7:0];
            end
        endcase
    endfunction

    function automatic string tag_of(vec_t v);
        if (is_illegal(v.idx, v.sz, v.hi, v.xb)) return "R7";
        if (v.sz != 2'b00 && (v.hi || v.xb))     return "R8";
        case (v.sz)
            2'b11:   return "R2";
            2'b10:   return "R3";
            2'b01:   return "R4";
            default: return v.hi ? "R6" : "R5";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // One write, then read back the full register and the written view.
    task automatic do_write(vec_t v);
        string t = tag_of(v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = v.idx; wr_size = v.sz;
        wr_hi = v.hi; wr_xb = v.xb; wr_data = v.d;
        #1;
        chk(t, "illegal_o", {63'h0, illegal}, {63'h0, is_illegal(v.idx, v.sz, v.hi, v.xb)});
        if (!is_illegal(v.idx, v.sz, v.hi, v.xb)) mdl_write(v.idx, v.sz, v.hi, v.d);
        @(negedge clk);
        wr_en = 1'b0;
        rd0_idx = v.idx; rd0_size = 2'b11; rd0_hi = 1'b0;
        rd1_idx = v.idx; rd1_size = v.sz;  rd1_hi = v.hi;
        #1;
        chk(t, "full register after write", rd0_data, mdl[v.idx]);
        chk("R9", "written view", rd1_data, mdl_view(v.idx, v.sz, v.hi));
    endtask

    task automatic check_all_views(logic [3:0] idx);
        for (int s = 0; s < 4; s++) begin
            for (int h = 0; h < 2; h++) begin
                @(negedge clk);
                rd0_idx = idx; rd0_size = 2'(s); rd0_hi = 1'(h);
                rd1_idx = idx; rd1_size = 2'(s); rd1_hi = 1'(h);
                #1;
                chk("R9", "view port0", rd0_data, mdl_view(idx, 2'(s), 1'(h)));
                chk("R9", "view port1", rd1_data, mdl_view(idx, 2'(s), 1'(h)));
            end
        end
    endtask

    task automatic check_all_zero(string what);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd0_idx = 4'(i); rd0_size = 2'b11; rd0_hi = 1'b0;
            #1;
            chk("R1", what, rd0_data, 64'h0);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_hi = 1'b0;
        wr_xb = 1'b0; wr_data = '0;
        rd0_idx = '0; rd0_size = 2'b11; rd0_hi = 1'b0;
        rd1_idx = '0; rd1_size = 2'b11; rd1_hi = 1'b0;
        for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all_zero("after reset");

        // Vector table walk (R2..R8 plus read-back R9)
        for (int k = 0; k < NV; k++) do_write(VECS[k]);

        check_all_views(4'd0);
        check_all_views(4'd3);
        check_all_views(4'd5);
        check_all_views(4'd15);

        // R11: idle write port holds everything and keeps illegal_o low
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 4'd2; wr_size = 2'b00; wr_hi = 1'b1; wr_xb = 1'b1;
        wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        #1;
        chk("R11", "illegal_o idle", {63'h0, illegal}, 64'h0);
        @(negedge clk);
        wr_size = 2'b11;
        rd0_idx = 4'd2; rd0_size = 2'b11; rd0_hi = 1'b0;
        #1;
        chk("R11", "idle write leaves reg2", rd0_data, mdl[2]);

        // R10: same-cycle read sees the old value, next cycle sees the new one
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd9; wr_size = 2'b11; wr_hi = 1'b0; wr_xb = 1'b0;
        wr_data = 64'h0F0F_1E1E_2D2D_3C3C;
        rd0_idx = 4'd9; rd0_size = 2'b11; rd0_hi = 1'b0;
        rd1_idx = 4'd9; rd1_size = 2'b10; rd1_hi = 1'b0;
        #1;
        chk("R10", "read during write port0", rd0_data, mdl[9]);
        chk("R10", "read during write port1", rd1_data, mdl_view(4'd9, 2'b10, 1'b0));
        mdl_write(4'd9, 2'b11, 1'b0, 64'h0F0F_1E1E_2D2D_3C3C);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R10", "read after write", rd0_data, 64'h0F0F_1E1E_2D2D_3C3C);

        // R9: high-byte read on index 4 is zero even with nonzero bits 15:8
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd4; wr_size = 2'b11; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        mdl_write(4'd4, 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        wr_en = 1'b0;
        rd0_idx = 4'd4; rd0_size = 2'b00; rd0_hi = 1'b1;
        #1;
        chk("R9", "high byte of index 4", rd0_data, 64'h0);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
        check_all_zero("after late reset");

        finish_run();
    end
endmodule